// File: doc/BRIEF.md
# Descriptor Ring DMA Pipe

This block is one uni-directional DMA pipe driven by a circular ring of 8-byte descriptors in system memory. Software writes descriptors into the ring. It then writes a producer byte offset into the pipe's event register. The pipe walks the ring from its own current offset up to, but not including, that producer offset. For each descriptor it performs one 64-bit memory read and hands the buffer address, byte count and flags to a downstream data mover over a valid/ready handshake. Offsets wrap to zero at the programmed ring size.

Only one descriptor is in flight at a time. The current offset moves on by 8 bytes once the mover has accepted the request, or at once for a descriptor whose byte count is zero. A descriptor whose interrupt flag is set produces a one-cycle interrupt pulse when it completes. Software can hold the pipe in reset, halt and resume it, and read back where it is in the ring.

Top module: `dring_pipe`

## Requirements
- R1: A descriptor read from memory is laid out with bits 31:0 holding the buffer address, bits 47:32 the byte count and bits 63:48 the flags. For each descriptor with a non-zero count, the mover request carries exactly that address, count and flags field.
- R2: The descriptor read address equals the ring base plus the current offset. No new read is issued until the previous descriptor has completed.
- R3: The pipe processes descriptors until the current offset equals the event offset. When the two are equal it stays idle and issues no memory read.
- R4: When the offset plus 8 reaches or passes the ring size, the next offset is 0.
- R5: A descriptor with a byte count of 0 raises no mover request, and the current offset still advances past it.
- R6: When a descriptor completes, `irq` pulses for exactly one cycle if flag bit 15 is set. Bits 14 (end of transfer) and 13 (end of block) reach the mover unchanged inside `mv_flags`.
- R7: While halt (index 2, bit 0) is 1, no new descriptor read starts and the current offset holds. Writing 0 resumes from the same offset.
- R8: While the reset register (index 1, bit 0) holds 1, writes to other registers have no effect and nothing is processed. Once it is set back to 0, every register reads its default: control 0, halt 0, base 0, size 0x8000, event 0, current 0.
- R9: Control register (index 0) bit 1 enables fetching, and no read is issued while it is 0. Bit 3 drives `mv_to_mem`. Bit 5 is stored. All other control bits read as 0.
- R10: The base (index 3), size (index 4) and event (index 5) registers always read with bits 2:0 equal to 0.
- R11: A mover request stays valid, with the same address, count and flags, until `mv_ready` is seen. During that time the current offset register (index 6) reads the offset of that descriptor.
- R12: Register indices 0 to 6 are control, reset, halt, base, size, event and current offset. Index 6 is read-only, and index 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | One-cycle descriptor read request |
| mem_addr | output | 32 | Byte address of the descriptor to read |
| mem_rvalid | input | 1 | Descriptor read data valid |
| mem_rdata | input | 64 | Descriptor read data |
| mv_valid | output | 1 | Mover request valid |
| mv_ready | input | 1 | Mover accepts request |
| mv_addr | output | 32 | Buffer address for the mover |
| mv_len | output | 16 | Byte count for the mover |
| mv_flags | output | 16 | Descriptor flags for the mover |
| mv_to_mem | output | 1 | Direction: 1 means peripheral to memory |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A wrong current offset shows up at the memory port: the next read request carries the wrong address, at the latest one descriptor later. A wrong wrap shows up the same way, on the first read after the ring end. The bench predicts every read address and every mover request from its own model of the ring and compares them in the cycle they occur. A lost or doubled completion therefore shows at once as a missing or extra request, and a stuck walker shows as an unmet expectation queue. Reset defaults, halt, enable and alignment masking are read back through the register port right after the stimulus.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int DATA_W     = 32;
  localparam int DESC_BYTES = 8;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] count;
    logic [31:0] addr;
  } desc_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_MOVE  = 2'd3
  } walk_st_e;

  localparam logic [2:0] RI_CTRL  = 3'd0;
  localparam logic [2:0] RI_RESET = 3'd1;
  localparam logic [2:0] RI_HALT  = 3'd2;
  localparam logic [2:0] RI_BASE  = 3'd3;
  localparam logic [2:0] RI_SIZE  = 3'd4;
  localparam logic [2:0] RI_EVENT = 3'd5;
  localparam logic [2:0] RI_CUR   = 3'd6;

  localparam int CTL_EN  = 1;
  localparam int CTL_P2M = 3;
  localparam int CTL_SYS = 5;
  localparam int FLG_IRQ = 15;
endpackage

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int RING_DEF = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [OFS_W-1:0]  cur_ofs,
  output logic              clr,
  output logic              enable,
  output logic              p2m,
  output logic              halt,
  output logic [ADDR_W-1:0] base,
  output logic [OFS_W-1:0]  size,
  output logic [OFS_W-1:0]  event_ofs
);
  localparam logic [OFS_W-1:0] SIZE_DEF = OFS_W'(RING_DEF);

  logic              hold_q, hold_d;
  logic              en_q, en_d, p2m_q, p2m_d, sys_q, sys_d;
  logic              halt_q, halt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [OFS_W-1:0]  size_q, size_d, evt_q, evt_d;
  logic              wr_ok;

  assign wr_ok = wr_en && !hold_q;

  always_comb begin
    hold_d = hold_q;
    en_d   = en_q;
    p2m_d  = p2m_q;
    sys_d  = sys_q;
    halt_d = halt_q;
    base_d = base_q;
    size_d = size_q;
    evt_d  = evt_q;
    if (wr_en && idx == RI_RESET) hold_d = wr_data[0];
    if (hold_q) begin
      en_d   = 1'b0;
      p2m_d  = 1'b0;
      sys_d  = 1'b0;
      halt_d = 1'b0;
      base_d = '0;
      size_d = SIZE_DEF;
      evt_d  = '0;
    end else if (wr_ok) begin
      case (idx)
        RI_CTRL: begin
          en_d  = wr_data[CTL_EN];
          p2m_d = wr_data[CTL_P2M];
          sys_d = wr_data[CTL_SYS];
        end
        RI_HALT:  halt_d = wr_data[0];
        RI_BASE:  base_d = {wr_data[ADDR_W-1:3], 3'b000};
        RI_SIZE:  size_d = {wr_data[OFS_W-1:3], 3'b000};
        RI_EVENT: evt_d  = {wr_data[OFS_W-1:3], 3'b000};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      en_q   <= 1'b0;
      p2m_q  <= 1'b0;
      sys_q  <= 1'b0;
      halt_q <= 1'b0;
      base_q <= '0;
      size_q <= SIZE_DEF;
      evt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      en_q   <= en_d;
      p2m_q  <= p2m_d;
      sys_q  <= sys_d;
      halt_q <= halt_d;
      base_q <= base_d;
      size_q <= size_d;
      evt_q  <= evt_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (idx)
      RI_CTRL: begin
        rd_data[CTL_EN]  = en_q;
        rd_data[CTL_P2M] = p2m_q;
        rd_data[CTL_SYS] = sys_q;
      end
      RI_RESET: rd_data[0] = hold_q;
      RI_HALT:  rd_data[0] = halt_q;
      RI_BASE:  rd_data[ADDR_W-1:0] = base_q;
      RI_SIZE:  rd_data[OFS_W-1:0]  = size_q;
      RI_EVENT: rd_data[OFS_W-1:0]  = evt_q;
      RI_CUR:   rd_data[OFS_W-1:0]  = cur_ofs;
      default:  rd_data = '0;
    endcase
  end

  assign clr       = hold_q;
  assign enable    = en_q;
  assign p2m       = p2m_q;
  assign halt      = halt_q;
  assign base      = base_q;
  assign size      = size_q;
  assign event_ofs = evt_q;

  // R8
  hold_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (size_q == SIZE_DEF && base_q == '0 && evt_q == '0 && !en_q && !halt_q));
  // R10
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q[2:0] == 3'b000 && size_q[2:0] == 3'b000 && evt_q[2:0] == 3'b000));
endmodule

// File: rtl/dring_walker.sv
module dring_walker
  import dring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              enable,
  input  logic              halt,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  size,
  input  logic [OFS_W-1:0]  event_ofs,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [31:0]       mv_addr,
  output logic [15:0]       mv_len,
  output logic [15:0]       mv_flags,
  output logic              irq,
  output logic [OFS_W-1:0]  cur_ofs
);
  localparam logic [OFS_W:0] STEP = (OFS_W+1)'(DESC_BYTES);

  walk_st_e         st_q, st_d;
  logic [OFS_W-1:0] cur_q, cur_d, nxt_ofs;
  logic [OFS_W:0]   sum;
  desc_t            rd_desc, desc_q;
  logic             go, adv, cur_ld, desc_ld;
  logic [15:0]      adv_flags;

  assign rd_desc = desc_t'(mem_rdata);
  assign go      = enable && !halt && (cur_q != event_ofs);
  assign sum     = {1'b0, cur_q} + STEP;
  assign nxt_ofs = (sum >= {1'b0, size}) ? '0 : sum[OFS_W-1:0];

  assign adv = !clr && (((st_q == ST_MOVE) && mv_ready) ||
                        ((st_q == ST_WAIT) && mem_rvalid && rd_desc.count == 16'd0));
  assign adv_flags = (st_q == ST_MOVE) ? desc_q.flags : rd_desc.flags;
  assign desc_ld   = !clr && (st_q == ST_WAIT) && mem_rvalid;
  assign cur_ld    = adv || clr;

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    if (clr) begin
      st_d  = ST_IDLE;
      cur_d = '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (go) st_d = ST_FETCH;
        ST_FETCH: st_d = ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid) begin
            if (rd_desc.count == 16'd0) begin
              st_d  = ST_IDLE;
              cur_d = nxt_ofs;
            end else begin
              st_d = ST_MOVE;
            end
          end
        end
        ST_MOVE: begin
          if (mv_ready) begin
            st_d  = ST_IDLE;
            cur_d = nxt_ofs;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
    end else begin
      st_q <= st_d;
      if (cur_ld) cur_q <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q <= '0;
    end else if (desc_ld) begin
      desc_q <= rd_desc;
    end
  end

  assign mem_req  = (st_q == ST_FETCH);
  assign mem_addr = base + {{(ADDR_W-OFS_W){1'b0}}, cur_q};
  assign mv_valid = (st_q == ST_MOVE);
  assign mv_addr  = desc_q.addr;
  assign mv_len   = desc_q.count;
  assign mv_flags = desc_q.flags;
  assign irq      = adv && adv_flags[FLG_IRQ];
  assign cur_ofs  = cur_q;

  // R11
  mv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready && !clr) |=>
      (mv_valid && $stable(mv_addr) && $stable(mv_len) && $stable(mv_flags) && $stable(cur_ofs)));
  // R7
  halt_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !mem_req);
  // R3
  idle_at_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cur_ofs == event_ofs) |=> !mem_req);
  // R8
  clr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cur_ofs == '0 && !mv_valid));
  // R2
  one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

// File: rtl/dring_pipe.sv
module dring_pipe
  import dring_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFS_W    = 16,
  parameter int RING_DEF = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [31:0]       mv_addr,
  output logic [15:0]       mv_len,
  output logic [15:0]       mv_flags,
  output logic              mv_to_mem,
  output logic              irq
);
  logic              clr, enable, p2m, halt;
  logic [ADDR_W-1:0] base;
  logic [OFS_W-1:0]  size, event_ofs, cur_ofs;

  dring_regs #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .RING_DEF(RING_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(reg_addr),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .cur_ofs(cur_ofs),
    .clr(clr), .enable(enable), .p2m(p2m), .halt(halt),
    .base(base), .size(size), .event_ofs(event_ofs)
  );

  dring_walker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enable(enable), .halt(halt),
    .base(base), .size(size), .event_ofs(event_ofs),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_addr(mv_addr),
    .mv_len(mv_len), .mv_flags(mv_flags), .irq(irq), .cur_ofs(cur_ofs)
  );

  assign mv_to_mem = p2m;

  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !mem_req);
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: tb/tb_dring_pipe.sv
module tb_dring_pipe;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mv_addr;
  logic [63:0] mem_rdata;
  logic        mv_valid, mv_ready, mv_to_mem, irq;
  logic [15:0] mv_len, mv_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  dring_pipe dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mv_valid(mv_valid), .mv_ready(mv_ready),
    .mv_addr(mv_addr), .mv_len(mv_len), .mv_flags(mv_flags),
    .mv_to_mem(mv_to_mem), .irq(irq)
  );

  typedef struct {
    logic [31:0] addr;
    logic [15:0] len;
    logic [15:0] flags;
  } mv_t;

  logic [63:0] mem [0:255];
  logic        p1;
  logic [31:0] a1;
  logic [31:0] q_fetch [$];
  mv_t         q_mv [$];
  int          checks = 0, errors = 0;
  int          irq_exp = 0, irq_seen = 0, fetch_cnt = 0, cyc = 0;
  int          m_ofs = 0, m_size = 32768;
  logic [31:0] m_base = 0;
  bit          rdy_mode = 0;
  bit          done = 0;

  // memory: two-cycle read latency
  always @(posedge clk) begin
    p1         <= mem_req;
    a1         <= mem_addr;
    mem_rvalid <= p1;
    mem_rdata  <= mem[a1[10:3]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      mv_ready = 1'b0;
    end else begin
      cyc++;
      mv_ready = rdy_mode ? (cyc % 3 == 0) : 1'b1;
      #1;
      if (mem_req) begin
        fetch_cnt++;
        if (q_fetch.size() == 0) chk("R3 unexpected fetch", mem_addr, 32'hFFFF_FFFF);
        else chk("R2 fetch address", mem_addr, q_fetch.pop_front());
      end
      if (mv_valid && mv_ready) begin
        if (q_mv.size() == 0) chk("R5 unexpected move", {16'h0, mv_len}, 32'hFFFF_FFFF);
        else begin
          mv_t e;
          e = q_mv.pop_front();
          chk("R1 move addr", mv_addr, e.addr);
          chk("R1 move len", {16'h0, mv_len}, {16'h0, e.len});
          chk("R6 move flags", {16'h0, mv_flags}, {16'h0, e.flags});
        end
      end
      if (irq) irq_seen++;
    end
  end

  task automatic wreg(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = idx;
    #2 d = reg_rdata;
  endtask

  task automatic add_desc(input logic [31:0] a, input logic [15:0] len, input logic [15:0] fl);
    logic [31:0] loc;
    loc = m_base + m_ofs;
    mem[loc[10:3]] = {fl, len, a};
    q_fetch.push_back(loc);
    if (len != 0) q_mv.push_back('{a, len, fl});
    if (fl[15]) irq_exp++;
    m_ofs = (m_ofs + 8 >= m_size) ? 0 : m_ofs + 8;
  endtask

  task automatic kick();
    wreg(3'd5, m_ofs);
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while ((q_fetch.size() != 0 || q_mv.size() != 0) && t < 3000) begin
      @(negedge clk); t++;
    end
    repeat (6) @(negedge clk);
    chk(req, (t < 3000), 1);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
    end
  end

  initial begin
    logic [31:0] v;
    int fc;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rreg(3'd0, v); chk("R9 ctrl after reset", v, 0);
    rreg(3'd4, v); chk("R8 size default", v, 32'h8000);
    rreg(3'd6, v); chk("R8 cur default", v, 0);
    chk("R11 no request after reset", {mv_valid, mem_req}, 0);
    rreg(3'd7, v); chk("R12 unmapped index", v, 0);

    // basic run
    m_base = 32'h200; wreg(3'd3, m_base);
    wreg(3'd0, 32'h22);
    chk("R9 direction bit clear", mv_to_mem, 0);
    add_desc(32'h1000_0000, 16'd100, 16'h0000);
    add_desc(32'h1000_1000, 16'd32760, 16'h4000);
    add_desc(32'h1000_2000, 16'd8, 16'hA000);
    kick(); wait_idle("R1 basic run drained");
    rreg(3'd6, v); chk("R3 cur reaches event", v, 24);
    chk("R6 irq count", irq_seen, irq_exp);

    // zero count descriptors
    add_desc(32'h2000_0000, 16'd0, 16'h8000);
    add_desc(32'h2000_0100, 16'd5, 16'h0000);
    kick(); wait_idle("R5 zero count drained");
    rreg(3'd6, v); chk("R5 cur advanced past empty", v, 40);
    chk("R6 irq on empty descriptor", irq_seen, irq_exp);

    // event equals current
    fc = fetch_cnt;
    wreg(3'd5, 40);
    repeat (20) @(negedge clk);
    chk("R3 idle when event equals cur", fetch_cnt, fc);

    // wrap with backpressure
    m_base = 32'h400; m_size = 64;
    wreg(3'd3, m_base); wreg(3'd4, m_size);
    rdy_mode = 1;
    for (int i = 0; i < 6; i++) add_desc(32'h3000_0000 + i*32'h40, 16'd16 + i[15:0], 16'h0000);
    kick();
    reg_addr = 3'd6;
    begin
      int t = 0;
      while (!mv_valid && t < 200) begin @(negedge clk); t++; end
      #2 chk("R11 cur reads in-flight offset", reg_rdata, 40);
    end
    wait_idle("R4 wrap run drained");
    rreg(3'd6, v); chk("R4 cur after wrap", v, 24);
    rdy_mode = 0;

    // halt
    wreg(3'd2, 1);
    fc = fetch_cnt;
    add_desc(32'h4000_0000, 16'd12, 16'h8000);
    add_desc(32'h4000_0040, 16'd12, 16'h0000);
    kick();
    repeat (20) @(negedge clk);
    chk("R7 no fetch while halted", fetch_cnt, fc);
    rreg(3'd6, v); chk("R7 cur held while halted", v, 24);
    wreg(3'd2, 0);
    wait_idle("R7 resume drained");
    rreg(3'd6, v); chk("R7 cur after resume", v, 40);

    // enable clear
    wreg(3'd0, 32'h28);
    chk("R9 direction bit set", mv_to_mem, 1);
    rreg(3'd0, v); chk("R9 ctrl readback", v, 32'h28);
    fc = fetch_cnt;
    add_desc(32'h5000_0000, 16'd4, 16'h2000);
    kick();
    repeat (20) @(negedge clk);
    chk("R9 no fetch when disabled", fetch_cnt, fc);
    wreg(3'd0, 32'h2A);
    wait_idle("R9 enabled run drained");
    rreg(3'd6, v); chk("R9 cur after enable", v, 48);

    // alignment masking
    wreg(3'd3, 32'h0000_0407);
    rreg(3'd3, v); chk("R10 base low bits", v, 32'h400);
    wreg(3'd4, 32'h43);
    rreg(3'd4, v); chk("R10 size low bits", v, 32'h40);
    wreg(3'd6, 32'h10);
    rreg(3'd6, v); chk("R12 cur is read-only", v, 48);

    // pipe reset
    wreg(3'd1, 1);
    wreg(3'd3, 32'h123);
    rreg(3'd3, v); chk("R8 write ignored during reset", v, 0);
    wreg(3'd1, 0);
    rreg(3'd0, v); chk("R8 ctrl default", v, 0);
    rreg(3'd2, v); chk("R8 halt default", v, 0);
    rreg(3'd4, v); chk("R8 size default again", v, 32'h8000);
    rreg(3'd5, v); chk("R8 event default", v, 0);
    rreg(3'd6, v); chk("R8 cur default again", v, 0);
    m_ofs = 0; m_base = 0; m_size = 32768;

    wreg(3'd0, 32'h22);
    add_desc(32'h6000_0000, 16'd64, 16'hE000);
    kick(); wait_idle("R2 post-reset run drained");
    rreg(3'd6, v); chk("R2 cur after post-reset run", v, 8);
    chk("R6 final irq count", irq_seen, irq_exp);

    done = 1;
    finish_up();
  end
endmodule